// File: doc/BRIEF.md
# Out-of-Order Issue Window with Register Hazard Matrices

This block keeps a small window of decoded instructions waiting to start execution and, every clock, picks at most one of them that can safely start, even when older entries in the window are still blocked. Each window row records, as one-hot register masks, which registers the instruction reads and which it writes. Alongside the window, a pending-write vector has one bit per register and marks registers whose result has not yet been written back.

The decoder offers one instruction per cycle as binary register fields with enable bits. The block turns these into masks and places the instruction in the first empty row. When a row issues, it leaves the window, the younger rows move up by one to close the gap, and the grant, the row index and the row's payload appear at the outputs. Write-completion pulses from the execution side clear pending-write bits. A branch whose outcome depends on registers holds back further refill until it has issued. A direct jump never occupies a row and only reloads the fetch counter.

Top module: `ooo_issue_window`

## Requirements
- R1: After reset the window is empty, every pending-write bit is clear, `fetch_pc` is 0, `issue_valid` is 0 and `dec_ready` is 1.
- R2: A row is not issued while any register it reads or writes has its pending-write bit set.
- R3: A row is not issued while an older valid row (lower row index, row 0 oldest) writes a register that this row reads.
- R4: A row is not issued while an older valid row reads or writes a register that this row writes.
- R5: Nothing issues while `fu_ready` is 0, and empty rows never issue.
- R6: Among rows allowed by R2 to R5, an eligible branch row is chosen if there is one, otherwise the eligible row with the lowest index. `issue_slot` gives that row index in binary, so a younger row issues while older rows are blocked.
- R7: Issuing a row sets the pending-write bit of each register it writes. A pulse on `wb_valid` clears the bit with binary index `wb_reg` at the clock edge, except that a set from an issue in the same cycle wins.
- R8: When a row issues, the rows below it move up one place and `issue_payload` carries the issued row's payload. An accepted instruction enters the first empty row after that removal. `dec_ready` is 1 only if such a row exists (or the offer is a jump) and R9 does not hold it back.
- R9: While a valid branch row (`dec_branch` was 1) is in the window and is not issuing in the current cycle, `dec_ready` is 0. In the cycle the branch issues, refill is allowed again.
- R10: An accepted offer with `dec_jump` at 1 enters no row and loads `fetch_pc` with `dec_target`.
- R11: Each accepted offer that enters a row increments `fetch_pc` by one.
- R12: For any instruction stream, register results written back in issue order equal those of strict in-order execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decoder offers an instruction this cycle |
| dec_jump | input | 1 | Offer is a direct jump (never enters the window) |
| dec_branch | input | 1 | Offer is a register-dependent branch |
| dec_ra_en | input | 1 | First source field is used |
| dec_ra | input | 3 | First source register, binary |
| dec_rb_en | input | 1 | Second source field is used |
| dec_rb | input | 3 | Second source register, binary |
| dec_rd_en | input | 1 | Destination field is used |
| dec_rd | input | 3 | Destination register, binary |
| dec_target | input | 16 | Jump target loaded into the fetch counter |
| dec_payload | input | 16 | Opaque tag carried with the row |
| dec_ready | output | 1 | Offer is accepted this cycle |
| fu_ready | input | 1 | Execution resources can take an instruction |
| wb_valid | input | 1 | A register write completes this cycle |
| wb_reg | input | 3 | Register whose write completes, binary |
| issue_valid | output | 1 | A row issues this cycle |
| issue_slot | output | 2 | Row index of the issued row, 0 is oldest |
| issue_branch | output | 1 | Issued row is a branch |
| issue_payload | output | 16 | Payload of the issued row |
| fetch_pc | output | 16 | Fetch counter |

## Verification
The hardest situation to reach is a pending-write bit being set by an issue in the very cycle a completion pulse names the same register, since a correct stream never completes a register that is not yet pending. A directed sequence forces it by pulsing completion for a register at the moment its writer issues, then shows a dependent reader staying blocked until a later genuine completion. Randomised streams over a reduced register set crowd the window with read-after-write, write-after-read and write-after-write conflicts, with branches and jumps mixed in, and each cycle's grant is compared against an independent model; the final register values are compared with in-order execution.

// File: rtl/sched_pkg.sv
// Shared types for the issue window.
// Assumes nothing beyond the standard; holds only the pick classification.
package sched_pkg;
    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_OLDEST = 2'd1,
        PICK_BRANCH = 2'd2
    } pick_e;
endpackage

// File: rtl/sched_onehot.sv
// Binary-to-one-hot converter for a register field.
// Assumes idx < NREG; an inactive enable yields an all-zero mask.
module sched_onehot #(
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic [AW-1:0]   idx,
    input  logic            en,
    output logic [NREG-1:0] mask
);
    // One comparator per register column.
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        assign mask[g] = en && (idx == AW'(g));
    end
endmodule

// File: rtl/sched_decode.sv
// Builds the read and write register masks of one offered instruction.
// Assumes a three-address format: two optional sources, one optional destination.
module sched_decode #(
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic            ra_en,
    input  logic [AW-1:0]   ra,
    input  logic            rb_en,
    input  logic [AW-1:0]   rb,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd,
    output logic [NREG-1:0] src_mask,
    output logic [NREG-1:0] dst_mask
);
    logic [NREG-1:0] a_mask, b_mask;

    sched_onehot #(.NREG(NREG), .AW(AW)) u_ra (.idx(ra), .en(ra_en), .mask(a_mask));
    sched_onehot #(.NREG(NREG), .AW(AW)) u_rb (.idx(rb), .en(rb_en), .mask(b_mask));
    sched_onehot #(.NREG(NREG), .AW(AW)) u_rd (.idx(rd), .en(rd_en), .mask(dst_mask));

    // Both source fields share one read mask.
    assign src_mask = a_mask | b_mask;
endmodule

// File: rtl/sched_hazard.sv
// Per-row eligibility: pending-write check plus comparison with all older rows.
// Assumes row 0 is the oldest and that invalid rows carry no meaning.
module sched_hazard #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] row_valid,
    input  logic [NREG-1:0]  row_src [DEPTH],
    input  logic [NREG-1:0]  row_dst [DEPTH],
    input  logic [NREG-1:0]  busy,
    input  logic             fu_ready,
    output logic [DEPTH-1:0] elig
);
    logic [NREG-1:0] above_wr  [DEPTH];
    logic [NREG-1:0] above_use [DEPTH];

    // Nothing lies above the oldest row.
    assign above_wr[0]  = '0;
    assign above_use[0] = '0;

    // Accumulate the columns written and touched by every older valid row.
    for (genvar g = 1; g < DEPTH; g++) begin : g_prefix
        assign above_wr[g]  = above_wr[g-1]  | (row_dst[g-1] & {NREG{row_valid[g-1]}});
        assign above_use[g] = above_use[g-1] |
                              ((row_src[g-1] | row_dst[g-1]) & {NREG{row_valid[g-1]}});
    end

    // A row may start only if no rule forbids it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign elig[g] = row_valid[g] && fu_ready
                      && !(|((row_src[g] | row_dst[g]) & busy))
                      && !(|(row_src[g] & above_wr[g]))
                      && !(|(row_dst[g] & above_use[g]));
    end
endmodule

// File: rtl/sched_select.sv
// Chooses one eligible row: a branch first, otherwise the oldest.
// Assumes at most one branch row is present at a time.
module sched_select
    import sched_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [DEPTH-1:0] row_br,
    output logic [DEPTH-1:0] grant,
    output logic [SW-1:0]    slot,
    output logic             any
);
    pick_e kind;

    // Scan from youngest to oldest so the oldest eligible row wins, then let a branch override.
    always_comb begin
        kind = PICK_NONE;
        slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                kind = PICK_OLDEST;
                slot = SW'(i);
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && row_br[i]) begin
                kind = PICK_BRANCH;
                slot = SW'(i);
            end
        end
    end

    // One-hot grant for the chosen row.
    always_comb begin
        any   = (kind != PICK_NONE);
        grant = '0;
        if (any) grant[slot] = 1'b1;
    end
endmodule

// File: rtl/sched_busy.sv
// Pending-write vector: one bit per register.
// Assumes at most one completion per cycle; a same-cycle set overrides a clear.
module sched_busy #(
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_mask,
    input  logic            clr_en,
    input  logic [AW-1:0]   clr_idx,
    output logic [NREG-1:0] busy
);
    logic [NREG-1:0] clr_mask;

    sched_onehot #(.NREG(NREG), .AW(AW)) u_clr (.idx(clr_idx), .en(clr_en), .mask(clr_mask));

    // Clear first, then set, so the set wins on the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/ooo_issue_window.sv
// Issue window: stores decoded rows, picks one per cycle, compacts upward, refills at the bottom.
// Assumes the decoder holds its offer until dec_ready and that completions name pending registers.
module ooo_issue_window #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    parameter int PW    = 16,
    parameter int PCW   = 16,
    localparam int AW   = $clog2(NREG),
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dec_valid,
    input  logic           dec_jump,
    input  logic           dec_branch,
    input  logic           dec_ra_en,
    input  logic [AW-1:0]  dec_ra,
    input  logic           dec_rb_en,
    input  logic [AW-1:0]  dec_rb,
    input  logic           dec_rd_en,
    input  logic [AW-1:0]  dec_rd,
    input  logic [PCW-1:0] dec_target,
    input  logic [PW-1:0]  dec_payload,
    output logic           dec_ready,
    input  logic           fu_ready,
    input  logic           wb_valid,
    input  logic [AW-1:0]  wb_reg,
    output logic           issue_valid,
    output logic [SW-1:0]  issue_slot,
    output logic           issue_branch,
    output logic [PW-1:0]  issue_payload,
    output logic [PCW-1:0] fetch_pc
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] row_valid, row_br, nxt_valid, nxt_br;
    logic [NREG-1:0]  row_src [DEPTH];
    logic [NREG-1:0]  row_dst [DEPTH];
    logic [PW-1:0]    row_pay [DEPTH];
    logic [NREG-1:0]  nxt_src [DEPTH];
    logic [NREG-1:0]  nxt_dst [DEPTH];
    logic [PW-1:0]    nxt_pay [DEPTH];

    logic [NREG-1:0]  dec_src, dec_dst, sel_src, sel_dst, busy;
    logic [DEPTH-1:0] elig, grant;
    logic [SW-1:0]    pick_slot;
    logic             pick_any;
    logic [CW-1:0]    occ, occ_after;
    logic             branch_pending, refill_hold, space, take_row, take_jump;

    sched_decode #(.NREG(NREG), .AW(AW)) u_dec (
        .ra_en(dec_ra_en), .ra(dec_ra), .rb_en(dec_rb_en), .rb(dec_rb),
        .rd_en(dec_rd_en), .rd(dec_rd), .src_mask(dec_src), .dst_mask(dec_dst)
    );

    sched_hazard #(.NREG(NREG), .DEPTH(DEPTH)) u_haz (
        .row_valid(row_valid), .row_src(row_src), .row_dst(row_dst),
        .busy(busy), .fu_ready(fu_ready), .elig(elig)
    );

    sched_select #(.DEPTH(DEPTH), .SW(SW)) u_sel (
        .elig(elig), .row_br(row_br), .grant(grant), .slot(pick_slot), .any(pick_any)
    );

    sched_busy #(.NREG(NREG), .AW(AW)) u_busy (
        .clk(clk), .rst_n(rst_n), .set_mask(sel_dst & {NREG{issue_valid}}),
        .clr_en(wb_valid), .clr_idx(wb_reg), .busy(busy)
    );

    // Issue outputs come straight from the chosen row.
    always_comb begin
        issue_valid   = pick_any;
        issue_slot    = pick_slot;
        issue_branch  = pick_any && row_br[pick_slot];
        issue_payload = row_pay[pick_slot];
        sel_src       = row_src[pick_slot];
        sel_dst       = row_dst[pick_slot];
    end

    // Count occupied rows before and after this cycle's removal.
    always_comb begin
        occ = '0;
        for (int r = 0; r < DEPTH; r++) occ = occ + CW'(row_valid[r]);
        occ_after = occ - CW'(issue_valid);
    end

    // Accept decision: space at the bottom and no branch holding refill.
    always_comb begin
        branch_pending = |(row_valid & row_br);
        refill_hold    = branch_pending && !(issue_valid && issue_branch);
        space          = occ_after < CW'(DEPTH);
        dec_ready      = !refill_hold && (dec_jump || space);
        take_row       = dec_valid && dec_ready && !dec_jump;
        take_jump      = dec_valid && dec_ready && dec_jump;
    end

    // Close the gap left by the issued row, then place the accepted instruction.
    always_comb begin
        for (int r = 0; r < DEPTH; r++) begin
            int from;
            from = (issue_valid && r >= int'(issue_slot)) ? r + 1 : r;
            if (from < DEPTH) begin
                nxt_valid[r] = row_valid[from];
                nxt_br[r]    = row_br[from];
                nxt_src[r]   = row_src[from];
                nxt_dst[r]   = row_dst[from];
                nxt_pay[r]   = row_pay[from];
            end else begin
                nxt_valid[r] = 1'b0;
                nxt_br[r]    = 1'b0;
                nxt_src[r]   = '0;
                nxt_dst[r]   = '0;
                nxt_pay[r]   = '0;
            end
            if (take_row && occ_after == CW'(r)) begin
                nxt_valid[r] = 1'b1;
                nxt_br[r]    = dec_branch;
                nxt_src[r]   = dec_src;
                nxt_dst[r]   = dec_dst;
                nxt_pay[r]   = dec_payload;
            end
        end
    end

    // Window storage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= '0;
            row_br    <= '0;
            for (int r = 0; r < DEPTH; r++) begin
                row_src[r] <= '0;
                row_dst[r] <= '0;
                row_pay[r] <= '0;
            end
        end else begin
            row_valid <= nxt_valid;
            row_br    <= nxt_br;
            for (int r = 0; r < DEPTH; r++) begin
                row_src[r] <= nxt_src[r];
                row_dst[r] <= nxt_dst[r];
                row_pay[r] <= nxt_pay[r];
            end
        end
    end

    // Fetch counter: jumps reload it, accepted rows advance it.
    always_ff @(posedge clk) begin
        if (!rst_n)         fetch_pc <= '0;
        else if (take_jump) fetch_pc <= dec_target;
        else if (take_row)  fetch_pc <= fetch_pc + PCW'(1);
    end
endmodule

// File: rtl/ooo_issue_window_chk.sv
// Property checker for the issue window, attached by bind.
// Assumes the internal names of ooo_issue_window are unchanged.
module ooo_issue_window_chk #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fu_ready,
    input logic             dec_valid,
    input logic             dec_jump,
    input logic             dec_ready,
    input logic             wb_valid,
    input logic [AW-1:0]    wb_reg,
    input logic             issue_valid,
    input logic             issue_branch,
    input logic [DEPTH-1:0] row_valid,
    input logic [DEPTH-1:0] row_br,
    input logic [DEPTH-1:0] elig,
    input logic [DEPTH-1:0] grant,
    input logic [NREG-1:0]  busy,
    input logic [NREG-1:0]  sel_src,
    input logic [NREG-1:0]  sel_dst
);
    // R5
    issue_needs_fu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> fu_ready);

    // R5
    grant_in_valid_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~row_valid) == '0);

    // R2
    issue_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (((sel_src | sel_dst) & busy) == '0));

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    branch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && |(elig & row_br)) |-> issue_branch);

    // R7
    pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> ((busy & $past(sel_dst)) == $past(sel_dst)));

    // R7
    pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(issue_valid && sel_dst[wb_reg])) |=> !busy[$past(wb_reg)]);

    // R9
    branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(row_valid & row_br) && !(issue_valid && issue_branch)) |-> !dec_ready);

    // R10
    jump_no_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready && dec_jump) |=>
        ($countones(row_valid) == $countones($past(row_valid)) - int'($past(issue_valid))));
endmodule

bind ooo_issue_window ooo_issue_window_chk #(.NREG(NREG), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fu_ready(fu_ready), .dec_valid(dec_valid),
    .dec_jump(dec_jump), .dec_ready(dec_ready), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_branch(issue_branch), .row_valid(row_valid),
    .row_br(row_br), .elig(elig), .grant(grant), .busy(busy),
    .sel_src(sel_src), .sel_dst(sel_dst)
);

// File: tb/ooo_issue_window_bench.sv
// Bench: reference window model checked every cycle, plus in-order result comparison.
module ooo_issue_window_bench;
    localparam int CLK_P = 10;
    localparam int NREG  = 8;
    localparam int DEPTH = 4;
    localparam int PW    = 16;
    localparam int PCW   = 16;
    localparam int MAXP  = 512;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dec_valid = 0, dec_jump = 0, dec_branch = 0;
    logic dec_ra_en = 0, dec_rb_en = 0, dec_rd_en = 0;
    logic [2:0] dec_ra = 0, dec_rb = 0, dec_rd = 0, wb_reg = 0;
    logic [PCW-1:0] dec_target = 0;
    logic [PW-1:0]  dec_payload = 0;
    logic fu_ready = 0, wb_valid = 0;
    logic dec_ready, issue_valid, issue_branch;
    logic [1:0] issue_slot;
    logic [PW-1:0] issue_payload;
    logic [PCW-1:0] fetch_pc;

    always #(CLK_P/2) clk = ~clk;

    ooo_issue_window #(.NREG(NREG), .DEPTH(DEPTH), .PW(PW), .PCW(PCW)) u_ooo_issue_window (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_jump(dec_jump),
        .dec_branch(dec_branch), .dec_ra_en(dec_ra_en), .dec_ra(dec_ra),
        .dec_rb_en(dec_rb_en), .dec_rb(dec_rb), .dec_rd_en(dec_rd_en), .dec_rd(dec_rd),
        .dec_target(dec_target), .dec_payload(dec_payload), .dec_ready(dec_ready),
        .fu_ready(fu_ready), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_branch(issue_branch),
        .issue_payload(issue_payload), .fetch_pc(fetch_pc)
    );

    int tests = 0, fails = 0;

    // Program: kind 0 = normal, 1 = register branch, 2 = direct jump.
    int         p_kind [MAXP];
    bit         p_aen [MAXP], p_ben [MAXP], p_den [MAXP];
    logic [2:0] p_ra [MAXP], p_rb [MAXP], p_rd [MAXP];
    logic [15:0] p_tgt [MAXP];

    // Reference window and machine state.
    bit              m_v [DEPTH], m_b [DEPTH];
    logic [NREG-1:0] m_s [DEPTH], m_d [DEPTH];
    int              m_id [DEPTH];
    logic [NREG-1:0] m_busy;
    logic [15:0]     m_pc;
    int regs [NREG];
    bit pend_v [NREG];
    int pend_val [NREG], pend_due [NREG];
    int cyc, lat_max, ooo_seen;

    // Per-step stimulus variables.
    bit d_v, fu, wv, last_accept;
    int d_id;
    logic [2:0] wr;

    function automatic int opval(int id, int a, int b);
        return a * 3 + b + id + 1;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 0; m_b[i] = 0; m_s[i] = '0; m_d[i] = '0; m_id[i] = 0;
        end
        for (int r = 0; r < NREG; r++) begin
            regs[r] = r * 17 + 5; pend_v[r] = 0; pend_val[r] = 0; pend_due[r] = 0;
        end
        m_busy = '0; m_pc = '0; cyc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; dec_valid = 0; dec_jump = 0; fu_ready = 0; wb_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    // One clock: drive, compare against the model, advance the model.
    task automatic step();
        int pick, occ, occ_a, from;
        bit stall, exp_rdy, brp;
        bit el [DEPTH];
        logic [NREG-1:0] up_w, up_u, setm, clrm;
        bit nv [DEPTH], nb [DEPTH];
        logic [NREG-1:0] ns [DEPTH], nd [DEPTH];
        int nid [DEPTH];
        @(negedge clk);
        dec_valid  = d_v;
        dec_jump   = d_v && p_kind[d_id] == 2;
        dec_branch = d_v && p_kind[d_id] == 1;
        dec_ra_en  = d_v && p_aen[d_id]; dec_ra = p_ra[d_id];
        dec_rb_en  = d_v && p_ben[d_id]; dec_rb = p_rb[d_id];
        dec_rd_en  = d_v && p_den[d_id]; dec_rd = p_rd[d_id];
        dec_target = p_tgt[d_id]; dec_payload = PW'(d_id);
        fu_ready = fu; wb_valid = wv; wb_reg = wr;
        #1;
        up_w = '0; up_u = '0; pick = -1; occ = 0; brp = 0;
        for (int i = 0; i < DEPTH; i++) begin
            el[i] = m_v[i] && fu && (((m_s[i] | m_d[i]) & m_busy) == '0)
                    && ((m_s[i] & up_w) == '0) && ((m_d[i] & up_u) == '0);
            if (m_v[i]) begin
                up_w |= m_d[i]; up_u |= m_s[i] | m_d[i]; occ++;
                if (m_b[i]) brp = 1;
            end
        end
        for (int i = 0; i < DEPTH; i++) if (el[i] && pick < 0) pick = i;
        for (int i = 0; i < DEPTH; i++) if (el[i] && m_b[i]) pick = i;
        occ_a   = occ - (pick >= 0 ? 1 : 0);
        stall   = brp && !(pick >= 0 && m_b[pick]);
        exp_rdy = !stall && ((d_v && p_kind[d_id] == 2) || occ_a < DEPTH);

        check(issue_valid == (pick >= 0), "R2 R3 R4 R5 issue_valid", issue_valid, pick >= 0);
        if (pick >= 0 && issue_valid) begin
            check(int'(issue_slot) == pick, "R6 issue_slot", issue_slot, pick);
            check(issue_payload == PW'(m_id[pick]), "R8 issue_payload", issue_payload, m_id[pick]);
            check(issue_branch == m_b[pick], "R9 issue_branch", issue_branch, m_b[pick]);
        end
        check(dec_ready == exp_rdy, "R8 R9 R10 dec_ready", dec_ready, exp_rdy);
        check(fetch_pc == m_pc, "R10 R11 fetch_pc", fetch_pc, m_pc);

        // Advance the model.
        setm = '0;
        if (pick >= 0) begin
            int id;
            id = m_id[pick];
            if (pick > 0) ooo_seen++;
            setm = m_d[pick];
            if (m_d[pick] != '0) begin
                pend_v[p_rd[id]]   = 1;
                pend_val[p_rd[id]] = opval(id, p_aen[id] ? regs[p_ra[id]] : 0,
                                               p_ben[id] ? regs[p_rb[id]] : 0);
                pend_due[p_rd[id]] = cyc + 1 + int'($urandom % lat_max);
            end
        end
        clrm = '0;
        if (wv) begin
            clrm[wr] = 1'b1;
            if (pend_v[wr] && pend_due[wr] <= cyc) begin
                regs[wr] = pend_val[wr]; pend_v[wr] = 0;
            end
        end
        m_busy = (m_busy & ~clrm) | setm;
        for (int r = 0; r < DEPTH; r++) begin
            from = (pick >= 0 && r >= pick) ? r + 1 : r;
            if (from < DEPTH) begin
                nv[r] = m_v[from]; nb[r] = m_b[from]; ns[r] = m_s[from];
                nd[r] = m_d[from]; nid[r] = m_id[from];
            end else begin
                nv[r] = 0; nb[r] = 0; ns[r] = '0; nd[r] = '0; nid[r] = 0;
            end
        end
        last_accept = d_v && exp_rdy;
        if (last_accept && p_kind[d_id] != 2) begin
            nv[occ_a] = 1; nb[occ_a] = (p_kind[d_id] == 1); nid[occ_a] = d_id;
            ns[occ_a] = ((NREG'(1) << p_ra[d_id]) & {NREG{p_aen[d_id]}})
                      | ((NREG'(1) << p_rb[d_id]) & {NREG{p_ben[d_id]}});
            nd[occ_a] = (NREG'(1) << p_rd[d_id]) & {NREG{p_den[d_id]}};
            m_pc = m_pc + 16'd1;
        end else if (last_accept) begin
            m_pc = p_tgt[d_id];
        end
        for (int r = 0; r < DEPTH; r++) begin
            m_v[r] = nv[r]; m_b[r] = nb[r]; m_s[r] = ns[r]; m_d[r] = nd[r]; m_id[r] = nid[r];
        end
        cyc++;
    endtask

    // Compare final register values with strict in-order execution.
    task automatic final_regs(int n);
        int ref_r [NREG];
        for (int r = 0; r < NREG; r++) ref_r[r] = r * 17 + 5;
        for (int k = 0; k < n; k++)
            if (p_kind[k] == 0 && p_den[k])
                ref_r[p_rd[k]] = opval(k, p_aen[k] ? ref_r[p_ra[k]] : 0,
                                          p_ben[k] ? ref_r[p_rb[k]] : 0);
        for (int r = 0; r < NREG; r++)
            check(regs[r] == ref_r[r], "R12 register result", regs[r], ref_r[r]);
    endtask

    function automatic bit window_empty();
        bit e;
        e = 1;
        for (int i = 0; i < DEPTH; i++) if (m_v[i]) e = 0;
        for (int r = 0; r < NREG; r++) if (pend_v[r]) e = 0;
        return e;
    endfunction

    task automatic run_phase(int n, int fu_pct, int br_pct, int jmp_pct, int lmax, int nregs);
        int pidx, guard;
        for (int k = 0; k < n; k++) begin
            int rnd;
            rnd = int'($urandom % 100);
            p_kind[k] = (rnd < jmp_pct) ? 2 : (rnd < jmp_pct + br_pct) ? 1 : 0;
            p_ra[k] = 3'($urandom % nregs); p_rb[k] = 3'($urandom % nregs);
            p_rd[k] = 3'($urandom % nregs); p_tgt[k] = 16'($urandom);
            p_aen[k] = p_kind[k] == 1 || (p_kind[k] == 0 && ($urandom % 100) < 80);
            p_ben[k] = p_kind[k] != 2 && ($urandom % 100) < 60;
            p_den[k] = p_kind[k] == 0 && ($urandom % 100) < 90;
        end
        lat_max = lmax;
        do_reset();
        pidx = 0; guard = 0;
        while (!(pidx == n && window_empty()) && guard < 20000) begin
            int found;
            d_v  = (pidx < n) && ($urandom % 100) < 85;
            d_id = (pidx < n) ? pidx : 0;
            fu   = ($urandom % 100) < fu_pct;
            found = -1;
            for (int r = NREG - 1; r >= 0; r--) if (pend_v[r] && pend_due[r] <= cyc) found = r;
            wv = 0; wr = 0;
            if (found >= 0) begin
                wv = 1; wr = 3'(found);
            end else if (($urandom % 100) < 8) begin
                int r;
                r = int'($urandom % NREG);
                if (!m_busy[r]) begin wv = 1; wr = 3'(r); end
            end
            step();
            if (last_accept) pidx++;
            guard++;
        end
        final_regs(n);
    endtask

    initial begin
        ooo_seen = 0; lat_max = 1; d_v = 0; d_id = 0; fu = 0; wv = 0; wr = 0;
        p_kind[0] = 0; p_aen[0] = 0; p_ben[0] = 0; p_den[0] = 0;
        p_ra[0] = 0; p_rb[0] = 0; p_rd[0] = 0; p_tgt[0] = 0;
        do_reset();
        #1;
        check(issue_valid == 0, "R1 issue_valid after reset", issue_valid, 0);
        check(dec_ready == 1, "R1 dec_ready after reset", dec_ready, 1);
        check(fetch_pc == 0, "R1 fetch_pc after reset", fetch_pc, 0);

        // Directed: completion pulse on a register in the cycle its writer issues.
        p_kind[0] = 0; p_aen[0] = 0; p_ben[0] = 0; p_den[0] = 1; p_rd[0] = 3'd5;
        p_kind[1] = 0; p_aen[1] = 1; p_ra[1] = 3'd5; p_ben[1] = 0; p_den[1] = 1; p_rd[1] = 3'd6;
        d_v = 1; d_id = 0; fu = 1; wv = 0; step();
        d_v = 1; d_id = 1; fu = 1; wv = 1; wr = 3'd5; step();
        check(issue_valid == 1, "R7 writer issues with same-cycle completion", issue_valid, 1);
        d_v = 0; wv = 0; step();
        check(issue_valid == 0, "R7 set wins over clear, reader held", issue_valid, 0);
        wv = 1; wr = 3'd5; step();
        wv = 0; step();
        check(issue_valid == 1, "R7 reader issues after completion", issue_valid, 1);
        check(issue_payload == 16'd1, "R7 reader payload", issue_payload, 1);
        wv = 1; wr = 3'd6; step();
        wv = 0; step();
        final_regs(2);

        // Randomised sweeps over different mixes.
        run_phase(300, 90, 5, 5, 3, 8);
        run_phase(300, 50, 5, 5, 4, 4);
        run_phase(250, 100, 20, 10, 2, 3);
        run_phase(300, 75, 0, 0, 6, 6);
        run_phase(200, 100, 10, 0, 1, 2);
        check(ooo_seen > 0, "R6 younger row issued past blocked older row", ooo_seen, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule